// File: doc/BRIEF.md
# Encoder Position Counter with Sticky Status Flags

This block keeps a 16-bit position count for an encoder-compare timer mode. Upstream logic has already turned encoder activity into qualified count strobes, each tagged as an up or a down step. While counting is enabled, every strobe moves the count by one in the tagged direction. The count wraps at both ends. Only an upward wrap is reported: it sets a sticky overflow flag and fires a one-cycle interrupt pulse.

A second flag records the direction of the most recent step. Software sees both flags through a two-bit status port. It may clear the overflow flag by writing 0 to it. Every other write leaves the flags alone, and reading never changes them.

A hold-control input decides what happens when counting is switched off. If hold is low, switching off clears both flags. If hold is high, both flags keep their values, so software can inspect them after the counter has stopped.

Top module: `enc_status_counter`

## Requirements
- R1: After reset the count is 16'h0000 and both flags and the interrupt are 0. A step happens only in a cycle with `count_en` and `cnt_stb` both high. Without a step the count holds.
- R2: A down step (`cnt_down`=1) decrements the count. A down step from 16'h0000 gives 16'hFFFF and sets neither the overflow flag nor the interrupt.
- R3: An up step from 16'hFFFF gives 16'h0000. The same clock edge sets the overflow flag and raises `ovf_irq`.
- R4: `ovf_irq` is high for exactly the cycle after each upward wrap, including when the overflow flag is already set.
- R5: The status word has the overflow flag on bit 0 and the direction flag on bit 1. A write with bit 0 = 0 clears the overflow flag. A write with bit 0 = 1 leaves it unchanged.
- R6: Reading is passive. The status word keeps showing the flags over any number of cycles until a step, write or disable changes them.
- R7: If a write of 0 to bit 0 and an upward wrap fall in the same cycle, the overflow flag ends at 1.
- R8: After an up step the direction flag is 0, and after a down step it is 1. A write to bit 1 never changes it.
- R9: When `count_en` falls from 1 to 0 while `hold_flags` is 0, both flags clear on that edge. The count keeps its value.
- R10: When `count_en` falls from 1 to 0 while `hold_flags` is 1, both flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_en | input | 1 | Counting enable; its falling edge is the disable event |
| cnt_stb | input | 1 | Qualified count strobe, one step per high cycle |
| cnt_down | input | 1 | Step direction: 0 up, 1 down |
| hold_flags | input | 1 | 1 keeps the flags over a disable; 0 clears them |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 2 | Write data: bit 0 overflow (only 0 acts), bit 1 direction (ignored) |
| reg_rdata | output | 2 | Status word: bit 1 direction, bit 0 overflow |
| count_q | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky encoder overflow flag |
| dir_flag | output | 1 | Direction of the last step |
| ovf_irq | output | 1 | One-cycle pulse per upward wrap |

## Verification
The assertions assume that a step can only occur while `count_en` is high. Because of that, the disable event and a wrap can never fall in the same cycle. They also assume that a write is a single-cycle strobe whose data is valid in that cycle. The stimulus changes inputs only on the falling clock edge. It raises `cnt_stb` together with `count_en` only when a step is intended. It creates every disable by lowering `count_en` with the strobe low, and it also tries strobes while disabled. Wrap conditions are reached by stepping down from zero rather than by long up-count runs.

// File: rtl/enc_ctr_pkg.sv
package enc_ctr_pkg;

    localparam int unsigned STAT_W   = 2;
    localparam int unsigned STAT_OVF = 0;
    localparam int unsigned STAT_DIR = 1;

    typedef struct packed {
        logic ovf;
        logic dir;
        logic irq;
        logic en_prev;
    } flag_state_t;

endpackage

// File: rtl/enc_ctr_count.sv
module enc_ctr_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             down,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap_up
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d   = cnt_q;
        wrap_up = 1'b0;
        if (step) begin
            if (down) begin
                cnt_d = cnt_q - CNT_ONE;
            end else begin
                cnt_d   = cnt_q + CNT_ONE;
                wrap_up = (cnt_q == CNT_MAX);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && down && cnt_q == '0) |=> (cnt_q == CNT_MAX)); // R2
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !down && cnt_q == CNT_MAX) |=> (cnt_q == '0)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q)); // R1

endmodule

// File: rtl/enc_ctr_flags.sv
module enc_ctr_flags
    import enc_ctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic              hold_flags,
    input  logic              step,
    input  logic              down,
    input  logic              wrap_up,
    input  logic              cpu_wr,
    input  logic [STAT_W-1:0] cpu_wdata,
    output logic              ovf_flag,
    output logic              dir_flag,
    output logic              ovf_irq
);
    flag_state_t st_d, st_q;
    logic        en_fall;
    logic        dis_clear;
    logic        sw_clear;

    always_comb begin
        en_fall    = st_q.en_prev && !count_en;
        dis_clear  = en_fall && !hold_flags;
        sw_clear   = cpu_wr && !cpu_wdata[STAT_OVF];

        st_d         = st_q;
        st_d.en_prev = count_en;
        st_d.irq     = wrap_up;
        if (sw_clear) st_d.ovf = 1'b0;
        if (step)     st_d.dir = down;
        if (dis_clear) begin
            st_d.ovf = 1'b0;
            st_d.dir = 1'b0;
        end
        if (wrap_up)  st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_flag = st_q.ovf;
    assign dir_flag = st_q.dir;
    assign ovf_irq  = st_q.irq;

    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_up |=> (ovf_flag && ovf_irq)); // R3
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_up |=> !ovf_irq); // R4
    AST_WR1_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_wdata[STAT_OVF] && !wrap_up && !dis_clear) |=> $stable(ovf_flag)); // R5
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && wrap_up) |=> ovf_flag); // R7
    AST_DIR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (dir_flag == $past(down))); // R8
    AST_DIR_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_wdata[STAT_DIR] && !step && !dis_clear) |=> $stable(dir_flag)); // R8
    AST_DIS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        dis_clear |=> (!ovf_flag && !dir_flag)); // R9
    AST_DIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_fall && hold_flags && !cpu_wr) |=> ($stable(ovf_flag) && $stable(dir_flag))); // R10

endmodule

// File: rtl/enc_status_counter.sv
module enc_status_counter
    import enc_ctr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic              cnt_stb,
    input  logic              cnt_down,
    input  logic              hold_flags,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic [CNT_W-1:0]  count_q,
    output logic              ovf_flag,
    output logic              dir_flag,
    output logic              ovf_irq
);
    logic cnt_step;
    logic wrap_up;

    assign cnt_step = count_en && cnt_stb;

    enc_ctr_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (cnt_step),
        .down    (cnt_down),
        .cnt_q   (count_q),
        .wrap_up (wrap_up)
    );

    enc_ctr_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en   (count_en),
        .hold_flags (hold_flags),
        .step       (cnt_step),
        .down       (cnt_down),
        .wrap_up    (wrap_up),
        .cpu_wr     (reg_wr),
        .cpu_wdata  (reg_wdata),
        .ovf_flag   (ovf_flag),
        .dir_flag   (dir_flag),
        .ovf_irq    (ovf_irq)
    );

    always_comb begin
        reg_rdata           = '0;
        reg_rdata[STAT_OVF] = ovf_flag;
        reg_rdata[STAT_DIR] = dir_flag;
    end

    AST_NO_COUNT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> $stable(count_q)); // R1
    AST_READ_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !cnt_step && count_en) |=> $stable(reg_rdata)); // R6

endmodule

// File: tb/enc_status_counter_tb.sv
`timescale 1ns/1ps
module enc_status_counter_tb;

    typedef struct {
        logic [15:0] cnt;
        logic        ovf;
        logic        dir;
        logic        irq;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_en = 1'b0, cnt_stb = 1'b0, cnt_down = 1'b0, hold_flags = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_wdata = 2'b00;
    logic [1:0]  reg_rdata;
    logic [15:0] count_q;
    logic        ovf_flag, dir_flag, ovf_irq;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    exp_t exp_q[$];

    logic [15:0] m_cnt = '0;
    logic        m_ovf = 1'b0, m_dir = 1'b0, m_irq = 1'b0, m_en = 1'b0;

    always #2.5 clk = ~clk;

    enc_status_counter u_dut (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .cnt_stb(cnt_stb),
        .cnt_down(cnt_down), .hold_flags(hold_flags), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_q(count_q),
        .ovf_flag(ovf_flag), .dir_flag(dir_flag), .ovf_irq(ovf_irq)
    );

    task automatic cyc(input logic en, input logic stb, input logic dn,
                       input logic hold, input logic wr, input logic [1:0] wd,
                       input string tag);
        logic stp, wrap, fall;
        exp_t e;
        @(negedge clk);
        count_en = en; cnt_stb = stb; cnt_down = dn; hold_flags = hold;
        reg_wr = wr; reg_wdata = wd;
        stp  = en && stb;
        fall = m_en && !en;
        wrap = stp && !dn && (m_cnt == 16'hFFFF);
        m_irq = wrap;
        if (wr && !wd[0]) m_ovf = 1'b0;
        if (stp) m_dir = dn;
        if (fall && !hold) begin m_ovf = 1'b0; m_dir = 1'b0; end
        if (wrap) m_ovf = 1'b1;
        if (stp) m_cnt = dn ? m_cnt - 16'd1 : m_cnt + 16'd1;
        m_en = en;
        @(posedge clk);
        #1;
        e.cnt = m_cnt; e.ovf = m_ovf; e.dir = m_dir; e.irq = m_irq; e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            wait (exp_q.size() > 0);
            e = exp_q.pop_front();
            n_chk++;
            if (count_q !== e.cnt || ovf_flag !== e.ovf || dir_flag !== e.dir ||
                ovf_irq !== e.irq || reg_rdata !== {e.dir, e.ovf}) begin
                n_bad++;
                $display("FAIL %s: got cnt=%h ovf=%b dir=%b irq=%b rd=%b exp cnt=%h ovf=%b dir=%b irq=%b",
                         e.tag, count_q, ovf_flag, dir_flag, ovf_irq, reg_rdata,
                         e.cnt, e.ovf, e.dir, e.irq);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not finish, exp=done");
        finish_run();
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (count_q !== 16'h0 || ovf_flag !== 1'b0 || dir_flag !== 1'b0 || ovf_irq !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got cnt=%h ovf=%b dir=%b irq=%b exp 0000 0 0 0",
                     count_q, ovf_flag, dir_flag, ovf_irq);
        end
        @(negedge clk); rst_n = 1'b1;
        // R1: strobe while disabled is ignored, then up steps
        cyc(0, 1, 0, 0, 0, 2'b00, "R1 strobe while disabled");
        cyc(1, 0, 0, 0, 0, 2'b00, "R1 enabled no strobe");
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, 2'b00, "R1 up step");
        for (int i = 0; i < 3; i++) cyc(1, 1, 1, 0, 0, 2'b00, "R2 down step");
        // R2: down wrap from zero, no overflow
        cyc(1, 1, 1, 0, 0, 2'b00, "R2 down wrap no flag");
        cyc(1, 0, 0, 0, 0, 2'b00, "R2 no irq after down wrap");
        // R3: up wrap sets flag and irq
        cyc(1, 1, 0, 0, 0, 2'b00, "R3 up wrap");
        cyc(1, 0, 0, 0, 0, 2'b00, "R4 irq drops");
        // R6: flags persist while idle
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 2'b00, "R6 read passive");
        // R5: write 1 ignored, write 0 clears
        cyc(1, 0, 0, 0, 1, 2'b01, "R5 write 1 ignored");
        cyc(1, 0, 0, 0, 1, 2'b00, "R5 write 0 clears");
        // R8: direction tracks, write to dir ignored
        cyc(1, 1, 1, 0, 0, 2'b00, "R8 down sets dir");
        cyc(1, 0, 0, 0, 1, 2'b01, "R8 dir write ignored");
        cyc(1, 1, 0, 0, 0, 2'b00, "R8 up clears dir");
        cyc(1, 0, 0, 0, 1, 2'b11, "R8 dir write 1 ignored");
        // R4: second wrap with flag already set
        cyc(1, 1, 1, 0, 0, 2'b00, "R4 prep down wrap");
        cyc(1, 1, 0, 0, 0, 2'b00, "R4 first wrap");
        cyc(1, 1, 1, 0, 0, 2'b00, "R4 prep again");
        cyc(1, 1, 0, 0, 0, 2'b00, "R4 wrap with flag set");
        cyc(1, 0, 0, 0, 0, 2'b00, "R4 single cycle");
        // R7: write 0 and wrap together
        cyc(1, 0, 0, 0, 1, 2'b00, "R7 clear first");
        cyc(1, 1, 1, 0, 0, 2'b00, "R7 prep");
        cyc(1, 1, 0, 0, 1, 2'b00, "R7 wrap beats clear");
        cyc(1, 1, 1, 0, 0, 2'b00, "R7 set dir");
        // R10: disable with hold keeps flags
        cyc(0, 0, 0, 1, 0, 2'b00, "R10 disable hold");
        cyc(0, 1, 0, 1, 0, 2'b00, "R10 strobe disabled");
        // R9: re-enable and disable without hold clears
        cyc(1, 0, 0, 0, 0, 2'b00, "R9 re-enable");
        cyc(0, 0, 0, 0, 0, 2'b00, "R9 disable clears");
        cyc(0, 0, 0, 0, 0, 2'b00, "R9 stays clear");
        @(negedge clk);
        wait (exp_q.size() == 0);
        #1;
        finish_run();
    end

endmodule